// File: doc/BRIEF.md
# Power-Fail Guarded SRAM Controller

This block sits between a synchronous host and an asynchronous byte-wide static RAM of 2,097,152 bytes (21 address lines, 8 data lines). The host issues one access at a time over a valid/ready request channel carrying an address, a write flag and write data. The block turns each request into a timed sequence of chip-enable, write-enable and output-enable strobes, with every interval counted in clock cycles. It finishes each access with a one-cycle response pulse that carries the captured read data and an error bit.

A digital supply-good flag from an external comparator guards every access. It is sampled on the same clock as the rest of the block. While the flag is low, the memory stays deselected and write-protected and no request is accepted. If the flag drops during an access, the strobes are released on the next clock and the access completes with an error. Once the flag returns, it must stay high for a programmable number of consecutive cycles before requests are accepted again.

The memory data bus is split into an output, an output enable and an input, so that the three-state pad can live outside this block.

Top module: `pfsram_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sram_ce_n_o`, `sram_we_n_o` and `sram_oe_n_o` are 1, `sram_dq_oe_o` is 0, `rsp_valid_o` is 0 and `req_ready_o` is 0.
- R2: `req_ready_o` is 1 only when no access is in progress, the lockout has been released and `pwr_good_i` is 1. A request is taken on a rising edge where `req_valid_i` and `req_ready_o` are both 1. Address and write data are latched there, so later changes on the request inputs do not affect the access.
- R3: A write (`req_wr_i`=1) drives the latched address and data (`sram_dq_oe_o`=1) from the cycle after acceptance. It then runs three phases:
  - T_SETUP cycles with chip enable low (0) and write enable high (1);
  - T_WPULSE cycles with both low;
  - T_HOLD cycles with both high.
  Address and data stay constant throughout all three phases.
- R4: Output enable stays high (1) during every cycle of a write.
- R5: A read (`req_wr_i`=0) holds chip enable and output enable low and write enable high for T_ACCESS cycles, with `sram_dq_oe_o`=0. `sram_dq_i` is registered at the edge that ends the last of these cycles and returned on `rsp_rdata_o`.
- R6: `rsp_valid_o` is a single-cycle pulse in the cycle right after the last strobe phase. That is T_SETUP+T_WPULSE+T_HOLD+1 cycles after acceptance for a write, and T_ACCESS+1 cycles for a read.
- R7: If `pwr_good_i` is 0 at a rising edge during any phase of an access, then in the following cycle all strobes are high, `sram_dq_oe_o` is 0, and `rsp_valid_o` and `rsp_err_o` are both 1.
- R8: While `pwr_good_i` is 0, `req_ready_o` stays 0 and no strobe goes low, whatever `req_valid_i` does.
- R9: After reset or after any low sample of `pwr_good_i`, `req_ready_o` first returns to 1 in the cycle after the T_RECOVER-th consecutive edge at which `pwr_good_i` is sampled 1. Any low sample restarts the count.
- R10: `rsp_err_o` is 1 only together with `rsp_valid_o`, and is 0 for every access that runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Supply-in-tolerance flag, synchronous to clk |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can take a request |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Response pulse, one cycle |
| rsp_err_o | output | 1 | Access aborted by supply failure |
| rsp_rdata_o | output | DATA_W | Captured read data |
| sram_ce_n_o | output | 1 | Chip enable, active low |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_dq_o | output | DATA_W | Data toward memory |
| sram_dq_oe_o | output | 1 | Drive enable for the data pads |
| sram_dq_i | input | DATA_W | Data from memory |

## Verification
Every cycle, the assertions check the rules that are strobe relations:
- write enable only inside chip enable, with output enable high;
- no bus drive while output enable is low;
- address and data frozen while write enable is low;
- deselection on the cycle after a low supply flag, and an error response when a supply drop hits an active access;
- the single-cycle response pulse, and the relock right after the flag rises.

Only the bench scenarios can show that the phase lengths match the parameters, that read data comes back from the right address, and that the recovery window opens on exactly the sixteenth good sample. The same holds for the count restarting after a brief glitch and for the error carried by aborted reads and writes.

// File: rtl/pfsram_pkg.sv
package pfsram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACCESS
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  function automatic strobe_t strobes_for(input seq_state_e s);
    strobe_t r;
    r = STROBE_IDLE;
    case (s)
      ST_WSETUP:  r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      ST_WPULSE:  r = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
      ST_WHOLD:   r = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      ST_RACCESS: r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
      default:    r = STROBE_IDLE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pfsram_lockout.sv
module pfsram_lockout #(
  parameter int T_RECOVER = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good_i,
  output logic access_ok_o
);
  localparam int CW = (T_RECOVER > 1) ? $clog2(T_RECOVER) : 1;
  localparam logic [CW-1:0] LAST = CW'(T_RECOVER - 1);

  logic [CW-1:0] good_cnt_q;
  logic          ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      good_cnt_q <= '0;
      ok_q       <= 1'b0;
    end else if (!pwr_good_i) begin
      good_cnt_q <= '0;
      ok_q       <= 1'b0;
    end else if (!ok_q) begin
      if (good_cnt_q == LAST) begin
        ok_q       <= 1'b1;
        good_cnt_q <= '0;
      end else begin
        good_cnt_q <= good_cnt_q + 1'b1;
      end
    end
  end

  assign access_ok_o = ok_q;
endmodule

// File: rtl/pfsram_seq.sv
module pfsram_seq
  import pfsram_pkg::*;
#(
  parameter int T_SETUP  = 2,
  parameter int T_WPULSE = 2,
  parameter int T_HOLD   = 2,
  parameter int T_ACCESS = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    pwr_good_i,
  input  logic    access_ok_i,
  input  logic    req_valid_i,
  input  logic    req_wr_i,
  output logic    req_ready_o,
  output logic    accept_o,
  output logic    capture_o,
  output logic    rsp_valid_o,
  output logic    rsp_err_o,
  output strobe_t strobe_o
);
  localparam int MAX_W  = (T_SETUP > T_WPULSE) ? T_SETUP : T_WPULSE;
  localparam int MAX_HA = (T_HOLD > T_ACCESS) ? T_HOLD : T_ACCESS;
  localparam int MAX_T  = (MAX_W > MAX_HA) ? MAX_W : MAX_HA;
  localparam int CW     = (MAX_T > 1) ? $clog2(MAX_T) : 1;

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done, abort;
  strobe_t       strobe_q;
  logic          rsp_valid_q, rsp_err_q;

  assign req_ready_o = (state_q == ST_IDLE) && access_ok_i && pwr_good_i;
  assign accept_o    = req_ready_o && req_valid_i;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    done      = 1'b0;
    abort     = 1'b0;
    capture_o = 1'b0;
    if (state_q == ST_IDLE) begin
      if (accept_o) begin
        state_d = req_wr_i ? ST_WSETUP : ST_RACCESS;
        cnt_d   = req_wr_i ? CW'(T_SETUP - 1) : CW'(T_ACCESS - 1);
      end
    end else if (!pwr_good_i) begin
      state_d = ST_IDLE;
      abort   = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      case (state_q)
        ST_WSETUP: begin
          state_d = ST_WPULSE;
          cnt_d   = CW'(T_WPULSE - 1);
        end
        ST_WPULSE: begin
          state_d = ST_WHOLD;
          cnt_d   = CW'(T_HOLD - 1);
        end
        ST_WHOLD: begin
          state_d = ST_IDLE;
          done    = 1'b1;
        end
        ST_RACCESS: begin
          state_d   = ST_IDLE;
          done      = 1'b1;
          capture_o = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      strobe_q    <= STROBE_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      strobe_q    <= strobes_for(state_d);
      rsp_valid_q <= done || abort;
      rsp_err_q   <= abort;
    end
  end

  assign strobe_o    = strobe_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
endmodule

// File: rtl/pfsram_datapath.sv
module pfsram_datapath #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (capture_i) begin
        rdata_q <= sram_dq_i;
      end
    end
  end

  assign sram_addr_o = addr_q;
  assign sram_dq_o   = wdata_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/pfsram_ctrl.sv
module pfsram_ctrl
  import pfsram_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 8,
  parameter int T_SETUP   = 2,
  parameter int T_WPULSE  = 2,
  parameter int T_HOLD    = 2,
  parameter int T_ACCESS  = 2,
  parameter int T_RECOVER = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              sram_ce_n_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  logic    access_ok;
  logic    accept, capture;
  strobe_t strobe;

  pfsram_lockout #(.T_RECOVER(T_RECOVER)) u_lockout (
    .clk         (clk),
    .rst         (rst),
    .pwr_good_i  (pwr_good_i),
    .access_ok_o (access_ok)
  );

  pfsram_seq #(
    .T_SETUP  (T_SETUP),
    .T_WPULSE (T_WPULSE),
    .T_HOLD   (T_HOLD),
    .T_ACCESS (T_ACCESS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .pwr_good_i  (pwr_good_i),
    .access_ok_i (access_ok),
    .req_valid_i (req_valid_i),
    .req_wr_i    (req_wr_i),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .capture_o   (capture),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .strobe_o    (strobe)
  );

  pfsram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .accept_i    (accept),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .sram_dq_i   (sram_dq_i),
    .sram_addr_o (sram_addr_o),
    .sram_dq_o   (sram_dq_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  assign sram_ce_n_o  = strobe.ce_n;
  assign sram_we_n_o  = strobe.we_n;
  assign sram_oe_n_o  = strobe.oe_n;
  assign sram_dq_oe_o = strobe.dq_oe;
endmodule

// File: rtl/pfsram_ctrl_chk.sv
module pfsram_ctrl_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_good_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic              sram_ce_n_o,
  input logic              sram_we_n_o,
  input logic              sram_oe_n_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe_o
);
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready_o |-> (sram_ce_n_o && sram_we_n_o && pwr_good_i));

  assert_we_inside_ce_R3: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n_o |-> (!sram_ce_n_o && sram_dq_oe_o));

  assert_addr_data_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n_o && $past(!sram_we_n_o)) |-> ($stable(sram_addr_o) && $stable(sram_dq_o)));

  assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n_o |-> sram_oe_n_o);

  assert_no_bus_fight_R5: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n_o |-> !sram_dq_oe_o);

  assert_rsp_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |=> !rsp_valid_o);

  assert_abort_response_R7: assert property (@(posedge clk) disable iff (rst)
    (!pwr_good_i && !sram_ce_n_o) |=> (rsp_valid_o && rsp_err_o));

  assert_deselect_on_fail_R8: assert property (@(posedge clk) disable iff (rst)
    !pwr_good_i |=> (sram_ce_n_o && sram_we_n_o && sram_oe_n_o && !sram_dq_oe_o));

  assert_relock_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_good_i) |=> !req_ready_o);

  assert_err_with_valid_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_err_o |-> rsp_valid_o);
endmodule

bind pfsram_ctrl pfsram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pwr_good_i   (pwr_good_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_err_o    (rsp_err_o),
  .sram_ce_n_o  (sram_ce_n_o),
  .sram_we_n_o  (sram_we_n_o),
  .sram_oe_n_o  (sram_oe_n_o),
  .sram_addr_o  (sram_addr_o),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/pfsram_ctrl_bench.sv
module pfsram_ctrl_bench;
  localparam int AW = 21, DW = 8;
  localparam int TS = 2, TW = 2, TH = 2, TA = 2, TR = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good_i = 1'b1;
  logic req_valid_i = 1'b0, req_wr_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic req_ready_o, rsp_valid_o, rsp_err_o;
  logic [DW-1:0] rsp_rdata_o, sram_dq_o;
  logic sram_ce_n_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o;
  logic [AW-1:0] sram_addr_o;
  logic [DW-1:0] sram_dq_i = '0;

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] sram_mem [logic [AW-1:0]];
  logic [DW-1:0] ref_mem [logic [AW-1:0]];
  logic [AW-1:0] used [0:63];
  int n_used = 0;

  always #2 clk = ~clk;

  pfsram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_SETUP(TS), .T_WPULSE(TW),
                .T_HOLD(TH), .T_ACCESS(TA), .T_RECOVER(TR)) u_pfsram_ctrl (.*);

  // Behavioural memory: stores while both strobes are low, returns data
  // half a cycle after a read is set up.
  always @(negedge clk) begin
    if (!sram_ce_n_o && !sram_we_n_o && sram_dq_oe_o) sram_mem[sram_addr_o] = sram_dq_o;
    if (!sram_ce_n_o && !sram_oe_n_o && sram_we_n_o)
      sram_dq_i <= sram_mem.exists(sram_addr_o) ? sram_mem[sram_addr_o] : 8'h00;
    else
      sram_dq_i <= 8'hEE;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int write_len();
    return TS + TW + TH + 1;
  endfunction

  // Count negedges until ready rises; R9 expects exactly TR.
  task automatic measure_recovery(input string tag);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!req_ready_o && k < 200);
    check(k == TR, tag, "recovery cycles", k, TR);
  endtask

  task automatic run_access(input logic wr, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input int fail_at);
    int n, n_set, n_pulse, n_hold, n_rd, bad_oe, bad_addr, bad_dq, waitc;
    logic [DW-1:0] exp_rd;
    n_set = 0; n_pulse = 0; n_hold = 0; n_rd = 0;
    bad_oe = 0; bad_addr = 0; bad_dq = 0; waitc = 0;
    exp_rd = ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    @(negedge clk);
    req_valid_i = 1'b1; req_wr_i = wr; req_addr_i = a; req_wdata_i = d;
    while (!req_ready_o && waitc < 200) begin
      @(negedge clk);
      waitc++;
    end
    check(waitc < 200, "R2", "handshake wait", waitc, 0);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    req_addr_i = AW'($urandom);
    req_wdata_i = DW'($urandom);
    n = 1;
    while (!rsp_valid_o && n < 100) begin
      if (sram_addr_o != a) bad_addr++;
      if (wr) begin
        if (!sram_oe_n_o) bad_oe++;
        if (sram_dq_oe_o && sram_dq_o != d) bad_dq++;
        if (!sram_ce_n_o && sram_we_n_o && sram_dq_oe_o) n_set++;
        else if (!sram_ce_n_o && !sram_we_n_o && sram_dq_oe_o) n_pulse++;
        else if (sram_ce_n_o && sram_we_n_o && sram_dq_oe_o) n_hold++;
      end else begin
        if (!sram_ce_n_o && !sram_oe_n_o && sram_we_n_o && !sram_dq_oe_o) n_rd++;
      end
      if (n == fail_at) pwr_good_i = 1'b0;
      @(negedge clk);
      n++;
    end
    if (fail_at > 0) begin
      check(n == fail_at + 1, "R7", "abort latency", n, fail_at + 1);
      check(rsp_err_o == 1'b1, "R7", "abort error flag", rsp_err_o, 1);
      check(sram_ce_n_o && sram_we_n_o && sram_oe_n_o && !sram_dq_oe_o, "R7",
            "strobes after abort",
            {sram_ce_n_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o}, 4'b1110);
      if (wr) ref_mem.delete(a);
    end else if (wr) begin
      check(n_set == TS, "R3", "setup cycles", n_set, TS);
      check(n_pulse == TW, "R3", "write pulse cycles", n_pulse, TW);
      check(n_hold == TH, "R3", "hold cycles", n_hold, TH);
      check(bad_addr == 0 && bad_dq == 0, "R3", "addr/data held", bad_addr + bad_dq, 0);
      check(bad_oe == 0, "R4", "oe low in write", bad_oe, 0);
      check(n == write_len(), "R6", "write response cycle", n, write_len());
      check(rsp_err_o == 1'b0, "R10", "write error flag", rsp_err_o, 0);
      ref_mem[a] = d;
      if (n_used < 64) begin
        used[n_used] = a;
        n_used++;
      end
    end else begin
      check(n_rd == TA && bad_addr == 0, "R5", "read strobe cycles", n_rd, TA);
      check(rsp_rdata_o == exp_rd, "R5", "read data", rsp_rdata_o, exp_rd);
      check(n == TA + 1, "R6", "read response cycle", n, TA + 1);
      check(rsp_err_o == 1'b0, "R10", "read error flag", rsp_err_o, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sram_ce_n_o && sram_we_n_o && sram_oe_n_o && !sram_dq_oe_o && !rsp_valid_o
          && !req_ready_o, "R1", "reset state",
          {sram_ce_n_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o, rsp_valid_o, req_ready_o},
          6'b111000);
    rst = 1'b0;
    measure_recovery("R9");

    // Directed corners: lowest and highest address, all-zero and all-one data
    run_access(1'b1, 21'h000000, 8'h00, -1);
    run_access(1'b1, 21'h1FFFFF, 8'hFF, -1);
    run_access(1'b0, 21'h1FFFFF, 8'h00, -1);
    run_access(1'b0, 21'h000000, 8'h00, -1);
    run_access(1'b1, 21'h0ABCDE, 8'h5A, -1);
    run_access(1'b0, 21'h0ABCDE, 8'h00, -1);

    // Constrained random mix of reads and writes
    for (int i = 0; i < 200; i++) begin
      logic [AW-1:0] a;
      if (($urandom % 10) < 6 || n_used == 0) begin
        a = (n_used > 0 && ($urandom % 4) == 0) ? used[$urandom % n_used] : AW'($urandom);
        run_access(1'b1, a, DW'($urandom), -1);
      end else begin
        a = used[$urandom % n_used];
        if (ref_mem.exists(a)) run_access(1'b0, a, 8'h00, -1);
        else run_access(1'b1, a, DW'($urandom), -1);
      end
    end

    // Supply drops during the write pulse: R7 abort
    run_access(1'b1, 21'h012345, 8'hC3, TS + 1);
    // R8: requests blocked while supply is bad
    begin
      int bad = 0;
      req_valid_i = 1'b1; req_wr_i = 1'b1; req_addr_i = 21'h000111;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (req_ready_o || !sram_ce_n_o || !sram_we_n_o) bad++;
      end
      req_valid_i = 1'b0;
      check(bad == 0, "R8", "access while supply bad", bad, 0);
    end
    pwr_good_i = 1'b1;
    measure_recovery("R9");

    // Supply drops during a read: R7 abort with error
    run_access(1'b0, 21'h1FFFFF, 8'h00, 1);
    // Glitch: high 10 cycles, low one sample, then full recovery window
    pwr_good_i = 1'b1;
    repeat (10) @(negedge clk);
    check(req_ready_o == 1'b0, "R9", "ready before window ends", req_ready_o, 0);
    pwr_good_i = 1'b0;
    @(negedge clk);
    pwr_good_i = 1'b1;
    measure_recovery("R9");

    // Normal service resumes after recovery
    run_access(1'b0, 21'h0ABCDE, 8'h00, -1);
    run_access(1'b1, 21'h000222, 8'h96, -1);
    run_access(1'b0, 21'h000222, 8'h00, -1);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule